// File: doc/BRIEF.md
# Program Memory Bank Mapper

This block sits between a 6502-style CPU and the banked program memories on a cartridge-style board. It watches the upper part of the CPU address space, 0x6000 to 0xFFFF. For every access in that space it produces a translated ROM address or work-RAM address, selects one of the two chips, and gates the RAM write enable. A small register file is written through the same CPU bus. It holds a window-layout mode, five bank registers and two write-protect code registers.

Four window layouts are available. The first is one 32 KB window. The second is two 16 KB windows. The third is one 16 KB window followed by two 8 KB windows. The fourth is four 8 KB windows. Bank registers 1 to 3 each carry their own choice between ROM and RAM in bit 7. Register 0 always maps RAM at 0x6000 to 0x7FFF. Register 4 always maps ROM at the top of memory. When one register feeds a 16 KB or 32 KB window, its low bank bits are replaced by CPU address bits, so that each 8 KB slice of the window lands in a distinct bank. Work-RAM writes are enabled only while the protect registers hold one exact pair of codes. All outputs are registered and valid one clock after the access address is presented.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, the mode reads back 0x03 (four 8 KB windows), bank register 4 reads back 0xFF (bit 7 set, last ROM bank 0x7F), bank registers 0 to 3 and both protect registers read 0x00, and rom_cs, ram_cs and ram_we are low.
- R2: An access in 0x6000 to 0x7FFF always selects RAM, with ram_addr = {bank register 0 bits 6:0, cpu_addr[12:0]}, in every mode.
- R3: An access in 0xE000 to 0xFFFF always selects ROM in every mode, using bank register 4. Bit 7 of register 4 is ignored, so it maps ROM even when that bit is clear.
- R4: In mode 3, the windows at 0x8000, 0xA000 and 0xC000 take registers 1, 2 and 3. In each, bit 7 = 1 selects ROM and bit 7 = 0 selects RAM, and the bank is bits 6:0.
- R5: In mode 2, register 2 maps 0x8000 to 0xBFFF as one 16 KB window with bank {reg[6:1], cpu_addr[13]}. Register 3 maps 0xC000 to 0xDFFF as an 8 KB window.
- R6: In mode 1, register 2 maps 0x8000 to 0xBFFF with bank {reg[6:1], cpu_addr[13]} and its own ROM/RAM choice. Register 4 maps 0xC000 to 0xFFFF as ROM with bank {reg[6:1], cpu_addr[13]}.
- R7: In mode 0, register 4 maps all of 0x8000 to 0xFFFF as ROM with bank {reg[6:2], cpu_addr[14:13]}. Registers 1 to 3 then have no effect.
- R8: The protect registers at 0x5102 and 0x5103 keep only their low two bits. ram_we rises for a RAM-mapped CPU write only while 0x5102 holds 2'b10 and 0x5103 holds 2'b01.
- R9: A CPU write to a ROM-mapped address is ignored: rom_cs is high and ram_we stays low, even while RAM writes are unlocked.
- R10: A register read at 0x5100, 0x5102, 0x5103 or 0x5113 to 0x5117 returns the stored value on reg_rdata one clock after reg_addr is presented. The mode returns in bits 1:0, and the protect codes return in bits 1:0.
- R11: An access below 0x6000 selects neither chip and raises no write enable.
- R12: Outputs for an access appear one clock after cpu_addr is presented. A register write is used by the first access presented after the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address, used for writes and read-back |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read-back of the register at reg_addr |
| cpu_addr | input | 16 | CPU access address |
| cpu_wr | input | 1 | CPU access is a write |
| rom_addr | output | 20 | Translated ROM address {bank, offset} |
| ram_addr | output | 20 | Translated work-RAM address {bank, offset} |
| rom_cs | output | 1 | ROM selected for this access |
| ram_cs | output | 1 | Work RAM selected for this access |
| ram_we | output | 1 | Work-RAM write enable |

## Verification
The assertions assume that cpu_addr and cpu_wr are held stable across each clock edge. They also assume that the registered outputs follow the address seen at the previous edge, so every property compares against the address one clock back and is armed only one clock after reset ends. The stimulus changes all inputs only on the falling edge, keeps register writes in cycles of their own with cpu_addr parked below 0x6000, and presents one access per clock. Each expected result therefore belongs to exactly one preceding address.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  typedef enum logic [1:0] {
    WIN_32K   = 2'd0,
    WIN_16K   = 2'd1,
    WIN_16_8K = 2'd2,
    WIN_8K    = 2'd3
  } win_mode_e;

  localparam int CPU_AW        = 16;
  localparam int NUM_BANK_REGS = 5;
  localparam int SEL_W         = $clog2(NUM_BANK_REGS);

  localparam logic [CPU_AW-1:0] MODE_ADDR   = 16'h5100;
  localparam logic [CPU_AW-1:0] LOCK_A_ADDR = 16'h5102;
  localparam logic [CPU_AW-1:0] LOCK_B_ADDR = 16'h5103;
  localparam logic [CPU_AW-1:0] BANK_BASE   = 16'h5113;

  localparam logic [1:0] LOCK_A_KEY = 2'b10;
  localparam logic [1:0] LOCK_B_KEY = 2'b01;
endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
  import prg_map_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-2:0] ROM_LAST = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [CPU_AW-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output win_mode_e                    mode,
  output logic [NUM_BANK_REGS-1:0][DATA_W-1:0] banks,
  output logic                         unlocked
);
  logic [1:0] lock_a, lock_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= WIN_8K;
      lock_a <= '0;
      lock_b <= '0;
    end else if (wr) begin
      if (addr == MODE_ADDR)   mode   <= win_mode_e'(wdata[1:0]);
      if (addr == LOCK_A_ADDR) lock_a <= wdata[1:0];
      if (addr == LOCK_B_ADDR) lock_b <= wdata[1:0];
    end
  end

  for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_bank
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == NUM_BANK_REGS - 1) ? {1'b1, ROM_LAST} : '0;
    localparam logic [CPU_AW-1:0] MY_ADDR = BANK_BASE + CPU_AW'(i);
    always_ff @(posedge clk) begin
      if (rst)                        banks[i] <= RST_VAL;
      else if (wr && addr == MY_ADDR) banks[i] <= wdata;
    end
  end

  assign unlocked = (lock_a == LOCK_A_KEY) && (lock_b == LOCK_B_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == MODE_ADDR)   rdata <= DATA_W'(mode);
      if (addr == LOCK_A_ADDR) rdata <= DATA_W'(lock_a);
      if (addr == LOCK_B_ADDR) rdata <= DATA_W'(lock_b);
      for (int i = 0; i < NUM_BANK_REGS; i++)
        if (addr == BANK_BASE + CPU_AW'(i)) rdata <= banks[i];
    end
  end
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 7
) (
  input  win_mode_e                             mode,
  input  logic [NUM_BANK_REGS-1:0][BANK_W:0]    banks,
  input  logic [CPU_AW-1:0]                     cpu_addr,
  output logic                                  hit,
  output logic                                  is_rom,
  output logic [BANK_W-1:0]                     bank
);
  logic [1:0]       slot;
  logic [SEL_W-1:0] sel;
  logic [1:0]       span;  // 0: 8 KB, 1: 16 KB, 2: 32 KB
  logic [BANK_W:0]  raw;

  assign slot = cpu_addr[14:13];

  always_comb begin
    hit  = 1'b0;
    sel  = SEL_W'(NUM_BANK_REGS - 1);
    span = 2'd0;
    if (cpu_addr[15]) begin
      hit = 1'b1;
      unique case (mode)
        WIN_32K: begin
          sel  = SEL_W'(4);
          span = 2'd2;
        end
        WIN_16K: begin
          sel  = slot[1] ? SEL_W'(4) : SEL_W'(2);
          span = 2'd1;
        end
        WIN_16_8K: begin
          if (!slot[1]) begin
            sel  = SEL_W'(2);
            span = 2'd1;
          end else begin
            sel = slot[0] ? SEL_W'(4) : SEL_W'(3);
          end
        end
        default: sel = SEL_W'({1'b0, slot}) + SEL_W'(1);
      endcase
    end else if (cpu_addr[14:13] == 2'b11) begin
      hit = 1'b1;
      sel = '0;
    end
  end

  always_comb begin
    raw = banks[sel];
    if (sel == SEL_W'(4))  is_rom = 1'b1;
    else if (sel == '0)    is_rom = 1'b0;
    else                   is_rom = raw[BANK_W];
    bank = raw[BANK_W-1:0];
    if (span == 2'd1)      bank[0]   = cpu_addr[13];
    else if (span == 2'd2) bank[1:0] = cpu_addr[14:13];
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 13,
  parameter logic [DATA_W-2:0] ROM_LAST = '1,
  localparam int BANK_W = DATA_W - 1,
  localparam int MEM_AW = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [15:0]       reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  output logic [MEM_AW-1:0] rom_addr,
  output logic [MEM_AW-1:0] ram_addr,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we
);
  win_mode_e                               mode;
  logic [NUM_BANK_REGS-1:0][DATA_W-1:0]    banks;
  logic                                    unlocked;
  logic                                    hit, is_rom;
  logic [BANK_W-1:0]                       bank;
  logic [MEM_AW-1:0]                       flat;

  prg_cfg_regs #(.DATA_W(DATA_W), .ROM_LAST(ROM_LAST)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode(mode), .banks(banks), .unlocked(unlocked)
  );

  prg_window_decode #(.BANK_W(BANK_W)) u_dec (
    .mode(mode), .banks(banks), .cpu_addr(cpu_addr),
    .hit(hit), .is_rom(is_rom), .bank(bank)
  );

  assign flat = {bank, cpu_addr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      ram_addr <= '0;
      rom_cs   <= 1'b0;
      ram_cs   <= 1'b0;
      ram_we   <= 1'b0;
    end else begin
      rom_addr <= flat;
      ram_addr <= flat;
      rom_cs   <= hit && is_rom;
      ram_cs   <= hit && !is_rom;
      ram_we   <= hit && !is_rom && cpu_wr && unlocked;
    end
  end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int MEM_AW = 20,
  parameter int OFS_W  = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic [MEM_AW-1:0] rom_addr,
  input logic [MEM_AW-1:0] ram_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_LOW_RAM: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(cpu_addr[15:13]) == 3'b011) |-> (ram_cs && !rom_cs)); // R2
  AST_TOP_ROM: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(cpu_addr[15:13]) == 3'b111) |-> (rom_cs && !ram_cs && !ram_we)); // R3
  AST_OFF_RANGE_IDLE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(cpu_addr) < 16'h6000) |-> (!rom_cs && !ram_cs && !ram_we)); // R11
  AST_ROM_WR_IGNORED: assert property (@(posedge clk) disable iff (rst || !armed)
    rom_cs |-> !ram_we); // R9
  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
    ram_we |-> (ram_cs && $past(cpu_wr))); // R8
  AST_OFFSET_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed)
    (rom_cs || ram_cs) |-> (rom_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])
                            && ram_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0]))); // R12
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.MEM_AW(MEM_AW), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;
  localparam int PERIOD = 10;

  typedef struct {
    bit          is_read;
    bit          rom;
    bit          ram;
    bit          we;
    logic [19:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, cpu_wr = 1'b0;
  logic [15:0] reg_addr = '0, cpu_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [19:0] rom_addr, ram_addr;
  logic        rom_cs, ram_cs, ram_we;

  int   n_vec = 0, n_bad = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  prg_bank_mapper u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; cpu_addr = '0; cpu_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; cpu_addr = '0; cpu_wr = 1'b0;
    e.is_read = 1'b1; e.rom = 0; e.ram = 0; e.we = 0; e.addr = '0; e.data = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic acc(input logic [15:0] a, input bit w, input bit rom, input bit ram,
                     input bit we, input logic [19:0] ea, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; cpu_addr = a; cpu_wr = w;
    e.is_read = 1'b0; e.rom = rom; e.ram = ram; e.we = we; e.addr = ea; e.data = '0; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one item per clock, sampled a quarter period after the edge.
  initial begin
    forever begin
      int n;
      exp_t e;
      @(posedge clk);
      n = q.size();
      #(PERIOD/4);
      if (n > 0) begin
        e = q.pop_front();
        n_vec++;
        if (e.is_read) begin
          if (reg_rdata !== e.data) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", e.tag, reg_rdata, e.data);
          end
        end else begin
          logic [19:0] got;
          got = e.rom ? rom_addr : ram_addr;
          if (rom_cs !== e.rom || ram_cs !== e.ram || ram_we !== e.we ||
              ((e.rom || e.ram) && got !== e.addr)) begin
            n_bad++;
            $display("FAIL %s: rom_cs=%b ram_cs=%b we=%b addr=%h expected %b %b %b %h",
                     e.tag, rom_cs, ram_cs, ram_we, got, e.rom, e.ram, e.we, e.addr);
          end
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle while the first post-reset access has not been presented
    n_vec++;
    if (rom_cs !== 1'b0 || ram_cs !== 1'b0 || ram_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: %b%b%b expected 000", rom_cs, ram_cs, ram_we);
    end
    rst = 1'b0;

    rd_reg(16'h5100, 8'h03, "R1 mode after reset");
    rd_reg(16'h5117, 8'hFF, "R1 reg4 after reset");
    rd_reg(16'h5113, 8'h00, "R1 reg0 after reset");
    rd_reg(16'h5103, 8'h00, "R1 protect after reset");
    acc(16'h1234, 0, 0, 0, 0, '0, "R11 low address idle");
    acc(16'h5FFF, 1, 0, 0, 0, '0, "R11 register space idle");
    acc(16'hFFFC, 0, 1, 0, 0, 20'hFFFFC, "R3 reset vector last bank");

    wr_reg(16'h5113, 8'h05);
    acc(16'h6010, 0, 0, 1, 0, 20'h0A010, "R2 R12 RAM window bank 5");
    rd_reg(16'h5113, 8'h05, "R10 reg0 readback");

    // mode 3
    wr_reg(16'h5114, 8'h83);
    wr_reg(16'h5115, 8'h04);
    wr_reg(16'h5116, 8'h90);
    acc(16'h8001, 0, 1, 0, 0, 20'h06001, "R4 8K slot0 ROM");
    acc(16'hA002, 0, 0, 1, 0, 20'h08002, "R4 8K slot1 RAM");
    acc(16'hC003, 0, 1, 0, 0, 20'h20003, "R4 8K slot2 ROM");
    wr_reg(16'h5117, 8'h12);
    acc(16'hE004, 0, 1, 0, 0, 20'h24004, "R3 reg4 bit7 clear still ROM");
    rd_reg(16'h5117, 8'h12, "R10 reg4 readback");

    // mode 2
    wr_reg(16'h5100, 8'h02);
    wr_reg(16'h5115, 8'h87);
    acc(16'h8005, 0, 1, 0, 0, 20'h0C005, "R5 16K lower half");
    acc(16'hA006, 0, 1, 0, 0, 20'h0E006, "R5 16K upper half");
    acc(16'hC007, 0, 1, 0, 0, 20'h20007, "R5 8K reg3");
    acc(16'hE008, 0, 1, 0, 0, 20'h24008, "R5 R3 8K reg4");
    acc(16'h6011, 0, 0, 1, 0, 20'h0A011, "R2 RAM window in mode 2");

    // mode 1
    wr_reg(16'h5100, 8'h01);
    rd_reg(16'h5100, 8'h01, "R10 mode readback");
    acc(16'h8005, 0, 1, 0, 0, 20'h0C005, "R6 16K reg2 ROM");
    acc(16'hC009, 0, 1, 0, 0, 20'h24009, "R6 16K reg4 lower");
    acc(16'hE00A, 0, 1, 0, 0, 20'h2600A, "R6 R3 16K reg4 upper");
    wr_reg(16'h5115, 8'h02);
    acc(16'hA00B, 0, 0, 1, 0, 20'h0600B, "R6 16K reg2 RAM");

    // mode 0, written with extra high bits that must be dropped
    wr_reg(16'h5100, 8'hFC);
    acc(16'h8000, 0, 1, 0, 0, 20'h20000, "R7 32K slice0");
    acc(16'hA001, 0, 1, 0, 0, 20'h22001, "R7 32K slice1");
    acc(16'hC002, 0, 1, 0, 0, 20'h24002, "R7 32K slice2");
    acc(16'hE003, 0, 1, 0, 0, 20'h26003, "R7 32K slice3");
    acc(16'h6012, 0, 0, 1, 0, 20'h0A012, "R2 RAM window in mode 0");

    // protect unlock
    wr_reg(16'h5100, 8'h03);
    wr_reg(16'h5114, 8'h01);
    acc(16'h6000, 1, 0, 1, 0, 20'h0A000, "R8 locked after reset");
    wr_reg(16'h5102, 8'h02);
    acc(16'h6000, 1, 0, 1, 0, 20'h0A000, "R8 only first code set");
    wr_reg(16'h5103, 8'h01);
    acc(16'h6000, 1, 0, 1, 1, 20'h0A000, "R8 unlocked RAM window");
    acc(16'h8003, 1, 0, 1, 1, 20'h02003, "R8 unlocked banked RAM");
    acc(16'h8003, 0, 0, 1, 0, 20'h02003, "R8 read gives no write enable");
    wr_reg(16'h5103, 8'hFD);
    rd_reg(16'h5103, 8'h01, "R8 R10 low bits only stored");
    acc(16'h6001, 1, 0, 1, 1, 20'h0A001, "R8 upper bits ignored");

    // ROM-region writes while unlocked
    wr_reg(16'h5114, 8'h81);
    acc(16'h8004, 1, 1, 0, 0, 20'h02004, "R9 write to ROM slot ignored");
    acc(16'hE005, 1, 1, 0, 0, 20'h24005, "R9 write to top ROM ignored");

    wr_reg(16'h5103, 8'h02);
    acc(16'h6002, 1, 0, 1, 0, 20'h0A002, "R8 relocked");
    rd_reg(16'h5102, 8'h02, "R10 protect A readback");
    rd_reg(16'h5103, 8'h02, "R10 protect B readback");

    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; cpu_addr = '0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule